// File: doc/BRIEF.md
# SPI Command Packet Receiver

This block is the target side of an SPI link that carries host command packets. A falling chip-select opens a transaction and a rising chip-select closes it. Incoming bytes are stored in a local buffer. The expected frame length is not taken from chip-select. It comes from header fields that depend on the leading version byte, because the host keeps clocking filler bytes until it sees an answer. On every byte shifted, the block returns a one-byte status code on MISO, so the host can tell when its packet has been taken.

When the full packet has arrived, the block emits a one-cycle ready pulse with the packet length. A downstream processor reads the packet through a synchronous read port. The block then refuses new transactions until the processor signals done and chip-select is high. SPI runs in mode 0, MSB first. SCLK, chip-select and MOSI are synchronised into the system clock, so SCLK must be well below a quarter of the system clock rate.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `pkt_ready` and `spi_miso` are low and the block accepts the next transaction.
- R2: Each byte on MISO is sent MSB first and changes after SCLK falls. It carries the status code of the current state, latched at the start of that byte: ready 0xF8, receiving 0xF9, processing 0xFA, not-ready 0xFB, bad-data 0xFC.
- R3: A chip-select fall in the ready state starts a frame. The bytes of the frame carry the receiving code until the frame is complete.
- R4: If byte 0 is 0xF0 or above, the frame is a legacy frame of 3 plus byte 2 bytes. On completion `pkt_ready` pulses for one cycle, `pkt_len` holds the byte count, and byte k of the frame is readable at buffer address k.
- R5: If byte 0 equals 0x03, the frame has an 8-byte header. Header bytes 6 (low) and 7 (high) give the data length, and the frame is 8 plus that length bytes.
- R6: A computed frame size that is zero or larger than DEPTH (256) gives the bad-data code from the next byte onward, until chip-select rises. No ready pulse is produced.
- R7: Any other value of byte 0 is rejected after byte 2, with the bad-data code and no ready pulse.
- R8: If chip-select rises before the frame is complete, the frame is dropped and the next transaction is accepted.
- R9: After completion the processing code is sent. The block leaves processing only when `proc_done` has been seen and chip-select is high. If chip-select is already high, it re-arms when done arrives. If done arrives first, it re-arms when chip-select rises.
- R10: A chip-select fall during processing sends the not-ready code, writes nothing to the buffer and produces no ready pulse.
- R11: While `enable` is low, chip-select edges are ignored: the ready code is sent and no frame is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows chip-select edges to start frames |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host (status codes) |
| pkt_ready | output | 1 | One-cycle pulse when a frame is complete |
| pkt_len | output | 9 | Byte count of the completed frame |
| proc_done | input | 1 | Processor has finished with the packet |
| buf_raddr | input | 8 | Buffer read address |
| buf_rdata | output | 8 | Buffer read data, one cycle after the address |

## Verification
The hardest state to reach from the ports is the deferred re-arm. A frame must complete, chip-select must rise while the processor still holds the packet, and a new transaction must then start before `proc_done`. The stimulus builds exactly that sequence. The bench checks that the new transaction sees only the not-ready code and that the buffer still holds the old packet. It then checks the opposite order, with done arriving while chip-select is low. Each MISO byte is compared against a queue of expected status codes, so every state change is checked at the byte where the host would see it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    S_READY = 2'd0,
    S_RECV  = 2'd1,
    S_PROC  = 2'd2,
    S_BAD   = 2'd3
  } rx_state_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic cs_n_s,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  logic [STAGES:0] sclk_p, cs_p, mosi_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk_in};
      cs_p   <= {cs_p[STAGES-1:0], cs_n_in};
      mosi_p <= {mosi_p[STAGES-1:0], mosi_in};
    end
  end

  assign cs_n_s    = cs_p[STAGES-1];
  assign cs_fall   = ~cs_p[STAGES-1] & cs_p[STAGES];
  assign cs_rise   = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
  assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_s,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       mosi_s,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      miso      <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {rx_sr, mosi_s};
        end
      end
      if (tx_load) begin
        miso  <= tx_byte[7];
        tx_sr <= {tx_byte[6:0], 1'b0};
      end else if (sclk_fall && !cs_n_s) begin
        if (bit_cnt == 3'd0) begin
          miso  <= tx_byte[7];
          tx_sr <= {tx_byte[6:0], 1'b0};
        end else begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_pkt_buf.sv
module spi_pkt_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_cmd_pkg::*;
#(
  parameter int         DEPTH     = 256,
  parameter int         HDR_LEN   = 8,
  parameter logic [7:0] PKT_VER   = 8'h03,
  parameter logic [7:0] LEG_BASE  = 8'hF0,
  parameter logic [7:0] ST_READY  = 8'hF8,
  parameter logic [7:0] ST_RECV   = 8'hF9,
  parameter logic [7:0] ST_PROC   = 8'hFA,
  parameter logic [7:0] ST_NOTRDY = 8'hFB,
  parameter logic [7:0] ST_BAD    = 8'hFC,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH),
  localparam int TW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          cs_n_s,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          byte_vld,
  input  logic [7:0]    byte_data,
  input  logic          proc_done,
  output rx_state_t     state,
  output logic [7:0]    status,
  output logic          tx_load,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          pkt_ready,
  output logic [LW-1:0] pkt_len
);
  logic [LW-1:0] cnt, cnt_n, need, need_n;
  logic          need_vld, set_need, go_bad, fin, refuse, done_q;
  logic [7:0]    first_q, lenlo_q;
  logic [TW-1:0] tot;

  always_comb begin
    cnt_n    = cnt + 1'b1;
    set_need = 1'b0;
    go_bad   = 1'b0;
    tot      = '0;
    if (!need_vld) begin
      if (cnt_n == LW'(3)) begin
        if (first_q == PKT_VER) begin
          set_need = 1'b0;
        end else if (first_q >= LEG_BASE) begin
          tot      = TW'(3) + TW'(byte_data);
          set_need = 1'b1;
        end else begin
          go_bad = 1'b1;
        end
      end else if (cnt_n == LW'(HDR_LEN) && first_q == PKT_VER) begin
        tot      = TW'(HDR_LEN) + TW'({byte_data, lenlo_q});
        set_need = 1'b1;
      end
      if (set_need && (tot == '0 || tot > TW'(DEPTH))) begin
        set_need = 1'b0;
        go_bad   = 1'b1;
      end
    end
    need_n = set_need ? LW'(tot) : need;
    fin    = !go_bad && (set_need || need_vld) && (need_n == cnt_n);
  end

  assign wr_en   = (state == S_RECV) && byte_vld && !cs_rise && (cnt < LW'(DEPTH));
  assign wr_addr = AW'(cnt);

  always_comb begin
    case (state)
      S_READY: status = ST_READY;
      S_RECV:  status = ST_RECV;
      S_PROC:  status = refuse ? ST_NOTRDY : ST_PROC;
      default: status = ST_BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_READY;
      cnt       <= '0;
      need      <= '0;
      need_vld  <= 1'b0;
      first_q   <= '0;
      lenlo_q   <= '0;
      refuse    <= 1'b0;
      done_q    <= 1'b0;
      tx_load   <= 1'b0;
      pkt_ready <= 1'b0;
      pkt_len   <= '0;
    end else begin
      tx_load   <= cs_fall;
      pkt_ready <= 1'b0;
      case (state)
        S_READY: begin
          if (enable && cs_fall) begin
            state    <= S_RECV;
            cnt      <= '0;
            need_vld <= 1'b0;
          end
        end
        S_RECV: begin
          if (cs_rise) begin
            state <= S_READY;
          end else if (byte_vld) begin
            cnt <= cnt_n;
            if (cnt == '0) first_q <= byte_data;
            if (cnt == LW'(HDR_LEN - 2)) lenlo_q <= byte_data;
            if (set_need) begin
              need     <= need_n;
              need_vld <= 1'b1;
            end
            if (go_bad) begin
              state <= S_BAD;
            end else if (fin) begin
              state     <= S_PROC;
              pkt_ready <= 1'b1;
              pkt_len   <= cnt_n;
              done_q    <= 1'b0;
              refuse    <= 1'b0;
            end
          end
        end
        S_PROC: begin
          if (cs_fall) refuse <= 1'b1;
          if (cs_rise) refuse <= 1'b0;
          if (proc_done) done_q <= 1'b1;
          if ((done_q || proc_done) && cs_n_s) begin
            state  <= S_READY;
            done_q <= 1'b0;
            refuse <= 1'b0;
          end
        end
        default: begin
          if (cs_rise) state <= S_READY;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int         DEPTH     = 256,
  parameter int         HDR_LEN   = 8,
  parameter int         SYNC_STG  = 2,
  parameter logic [7:0] PKT_VER   = 8'h03,
  parameter logic [7:0] LEG_BASE  = 8'hF0,
  parameter logic [7:0] ST_READY  = 8'hF8,
  parameter logic [7:0] ST_RECV   = 8'hF9,
  parameter logic [7:0] ST_PROC   = 8'hFA,
  parameter logic [7:0] ST_NOTRDY = 8'hFB,
  parameter logic [7:0] ST_BAD    = 8'hFC,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          pkt_ready,
  output logic [LW-1:0] pkt_len,
  input  logic          proc_done,
  input  logic [AW-1:0] buf_raddr,
  output logic [7:0]    buf_rdata
);
  logic          cs_n_s, cs_fall, cs_rise, sclk_rise, sclk_fall, mosi_s;
  logic          byte_vld, tx_load, wr_en;
  logic [7:0]    byte_data, status;
  logic [AW-1:0] wr_addr;
  rx_state_t     st_w;

  spi_cmd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
    .cs_n_s(cs_n_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s)
  );

  spi_byte_shift u_shift (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi_s(mosi_s), .tx_load(tx_load), .tx_byte(status),
    .byte_vld(byte_vld), .byte_data(byte_data), .miso(spi_miso)
  );

  spi_frame_ctl #(
    .DEPTH(DEPTH), .HDR_LEN(HDR_LEN), .PKT_VER(PKT_VER), .LEG_BASE(LEG_BASE),
    .ST_READY(ST_READY), .ST_RECV(ST_RECV), .ST_PROC(ST_PROC),
    .ST_NOTRDY(ST_NOTRDY), .ST_BAD(ST_BAD)
  ) u_ctl (
    .clk(clk), .rst(rst), .enable(enable), .cs_n_s(cs_n_s), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .byte_vld(byte_vld), .byte_data(byte_data), .proc_done(proc_done),
    .state(st_w), .status(status), .tx_load(tx_load), .wr_en(wr_en), .wr_addr(wr_addr),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len)
  );

  spi_pkt_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(byte_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          cs_n_s,
  input logic          proc_done,
  input rx_state_t     st,
  input logic          pkt_ready,
  input logic [LW-1:0] pkt_len
);
  // R4: the ready indication lasts one cycle
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |=> !pkt_ready);

  // R6: no reported length is zero or beyond the buffer
  assert_len_bound_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |-> (pkt_len != '0 && pkt_len <= LW'(DEPTH)));

  // R11: a disabled block stays ready
  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!enable && st == S_READY) |=> st == S_READY);

  // R9: processing persists while chip-select is held low
  assert_proc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_PROC && !cs_n_s) |=> st == S_PROC);

  // R7: the bad state only exits to ready
  assert_bad_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_BAD) |=> (st == S_BAD || st == S_READY));

  // R9: leaving processing needs done seen and chip-select high
  assert_proc_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_PROC && !proc_done && !cs_n_s) |=> st != S_READY);
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .cs_n_s(cs_n_s), .proc_done(proc_done),
  .st(st_w), .pkt_ready(pkt_ready), .pkt_len(pkt_len)
);

// File: tb/sim_spi_cmd_rx.sv
`timescale 1ns/1ps
module sim_spi_cmd_rx;
  localparam int DEPTH = 256;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam int HALF = 10;
  localparam logic [7:0] C_READY = 8'hF8, C_RECV = 8'hF9, C_PROC = 8'hFA,
                         C_NOTRDY = 8'hFB, C_BAD = 8'hFC;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, proc_done = 1'b0;
  logic miso, pkt_ready;
  logic [LW-1:0] pkt_len;
  logic [AW-1:0] raddr = '0;
  logic [7:0] rdata;

  int checks = 0, fails = 0, pkt_cnt = 0, last_len = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  spi_cmd_rx u0 (
    .clk(clk), .rst(rst), .enable(enable), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
    .proc_done(proc_done), .buf_raddr(raddr), .buf_rdata(rdata)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each MISO byte against the scoreboard
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] a = act_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, a, e);
    end
    if (pkt_ready) begin
      pkt_cnt++;
      last_len = pkt_len;
    end
  end

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF + 4) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, input logic [7:0] e, input string t);
    logic [7:0] got;
    exp_q.push_back(e);
    tag_q.push_back(t);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      got[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    act_q.push_back(got);
  endtask

  task automatic done_pulse();
    proc_done = 1'b1;
    @(negedge clk);
    proc_done = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input int a, output int v);
    raddr = AW'(a);
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    int n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 pkt_ready after reset", pkt_ready, 0);
    chk("R1 miso after reset", miso, 0);

    // R4 legacy frame of 3+3 bytes, R2/R3 status codes per byte
    cs_low();
    xfer(8'hF2, C_RECV, "R3 legacy b0");
    xfer(8'h11, C_RECV, "R3 legacy b1");
    xfer(8'h03, C_RECV, "R3 legacy b2");
    xfer(8'hA1, C_RECV, "R3 legacy b3");
    xfer(8'hA2, C_RECV, "R3 legacy b4");
    xfer(8'hA3, C_RECV, "R2 legacy last");
    xfer(8'h00, C_PROC, "R9 filler proc");
    xfer(8'h00, C_PROC, "R9 filler proc 2");
    cs_high();
    chk("R4 pkt count", pkt_cnt, 1);
    chk("R4 pkt_len", last_len, 6);
    rd(0, v); chk("R4 buf[0]", v, 8'hF2);
    rd(3, v); chk("R4 buf[3]", v, 8'hA1);
    rd(5, v); chk("R4 buf[5]", v, 8'hA3);

    // R10 deferred re-arm: new transaction while still processing
    cs_low();
    xfer(8'hF0, C_NOTRDY, "R10 not-ready b0");
    xfer(8'h77, C_NOTRDY, "R10 not-ready b1");
    xfer(8'h00, C_NOTRDY, "R10 not-ready b2");
    cs_high();
    chk("R10 no pkt", pkt_cnt, 1);
    rd(0, v); chk("R10 buf[0] kept", v, 8'hF2);
    rd(1, v); chk("R10 buf[1] kept", v, 8'h11);
    done_pulse();

    // R5 packet frame, 8-byte header plus 4 data bytes
    cs_low();
    xfer(8'h03, C_RECV, "R5 hdr0");
    for (int i = 1; i < 6; i++) xfer(8'(i), C_RECV, "R5 hdr");
    xfer(8'h04, C_RECV, "R5 len lo");
    xfer(8'h00, C_RECV, "R5 len hi");
    for (int i = 0; i < 4; i++) xfer(8'hD0 + 8'(i), C_RECV, "R5 data");
    xfer(8'h00, C_PROC, "R5 filler proc");
    done_pulse();
    xfer(8'h00, C_PROC, "R9 done before cs rise");
    cs_high();
    chk("R5 pkt count", pkt_cnt, 2);
    chk("R5 pkt_len", last_len, 12);
    rd(8, v); chk("R5 buf[8]", v, 8'hD0);
    rd(11, v); chk("R5 buf[11]", v, 8'hD3);

    // R6 oversize: 8 + 249 = 257 > 256; also proves R9 re-arm on cs rise
    cs_low();
    xfer(8'h03, C_RECV, "R9 rearmed");
    for (int i = 1; i < 6; i++) xfer(8'h00, C_RECV, "R6 hdr");
    xfer(8'hF9, C_RECV, "R6 len lo");
    xfer(8'h00, C_RECV, "R6 len hi");
    xfer(8'h00, C_BAD, "R6 bad after header");
    xfer(8'h00, C_BAD, "R6 bad again");
    cs_high();
    chk("R6 no pkt", pkt_cnt, 2);

    // R6 zero size: packet header must never give zero, legacy with len 0 is 3
    // R7 unrecognised version byte
    cs_low();
    xfer(8'h40, C_RECV, "R7 b0");
    xfer(8'h01, C_RECV, "R7 b1");
    xfer(8'h02, C_RECV, "R7 b2");
    xfer(8'h00, C_BAD, "R7 bad b3");
    xfer(8'h00, C_BAD, "R7 bad b4");
    cs_high();
    chk("R7 no pkt", pkt_cnt, 2);

    // R8 early release, then a minimal legacy frame
    cs_low();
    xfer(8'hF0, C_RECV, "R8 b0");
    xfer(8'h01, C_RECV, "R8 b1");
    xfer(8'h0A, C_RECV, "R8 b2");
    xfer(8'h55, C_RECV, "R8 b3");
    cs_high();
    chk("R8 no pkt", pkt_cnt, 2);
    cs_low();
    xfer(8'hF1, C_RECV, "R8 next b0");
    xfer(8'h22, C_RECV, "R8 next b1");
    xfer(8'h00, C_RECV, "R4 len zero b2");
    xfer(8'h00, C_PROC, "R4 len zero proc");
    cs_high();
    chk("R8 pkt count", pkt_cnt, 3);
    chk("R4 min pkt_len", last_len, 3);
    done_pulse();

    // R11 disabled: edges ignored
    enable = 1'b0;
    n0 = pkt_cnt;
    cs_low();
    xfer(8'hF2, C_READY, "R11 b0");
    xfer(8'h01, C_READY, "R11 b1");
    xfer(8'h00, C_READY, "R11 b2");
    xfer(8'h00, C_READY, "R11 b3");
    cs_high();
    chk("R11 no pkt", pkt_cnt, n0);
    rd(1, v); chk("R11 buf[1] kept", v, 8'h22);
    enable = 1'b1;

    repeat (20) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule